// File: doc/BRIEF.md
# Single-Level Interrupt Entry Controller

This block handles interrupt entry and return for a 32-bit processor that has one enable flag and no priority levels. The sequencer raises a fetch-start strobe at the first step of every instruction fetch. If a request is pending and interrupts are enabled at that moment, the block records the current program counter and a 16-bit source descriptor. It then clears the enable flag and redirects the program counter to a vector built from an 8-bit source code. One clock later it raises a one-cycle acknowledge. If no request is taken, the fetch goes on unchanged.

The same block executes five decoded opcodes that the instruction decoder presents with a valid strobe:
- Enable (10) sets the enable flag.
- Disable (11) clears it.
- Save (16) writes the held descriptor and the held program counter out through two register write ports.
- Restore (17) loads both held values from two register read ports.
- Return (29) reloads the program counter from the held value and sets the enable flag in the same clock, so no interrupt can slip in between the two.

All outputs are registered. A request or opcode sampled at one rising edge is visible at the outputs just after that edge.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After reset the enable flag (`ie`) is 0. `irq_ack`, `pc_load` and `wr_en` are 0, and the held program counter and descriptor are both zero, so a Save right after reset writes zeros.
- R2: At a rising edge where `fetch_start`, `irq_req` and `ie` are all 1, the interrupt is taken. After that edge `irq_ack` and `pc_load` are both 1.
- R3: `irq_ack` stays high for exactly one clock for each accepted request.
- R4: On entry, `pc_out` equals zero in bits 31..12, `irq_code` in bits 11..4, and zero in bits 3..0.
- R5: On entry the block holds `pc_in` as the saved program counter and `irq_info` as the saved descriptor, and it clears `ie`.
- R6: While `ie` is 0, a request held high through any number of fetch starts is not taken. It is taken at the first fetch start after `ie` becomes 1.
- R7: Return (opcode 29) drives `pc_load` high with `pc_out` equal to the saved program counter. It sets `ie` at the same edge. Outside entry and Return, `pc_load` is 0 and `pc_out` is zero.
- R8: Opcode 10 sets `ie`, and opcode 11 clears it.
- R9: Save (opcode 16) raises `wr_en` for one clock. At the same time `wr_info_val` carries the saved descriptor zero-extended to 32 bits, and `wr_pc_val` carries the saved program counter. Outside Save, `wr_en` is 0 and both write values are zero.
- R10: Restore (opcode 17) loads the saved descriptor from `rd_info_val` and the saved program counter from `rd_pc_val`.
- R11: An interrupt taken at an edge overrides any opcode presented at that edge, and that opcode has no effect. Opcodes other than 10, 11, 16, 17 and 29 also have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_start | input | 1 | First step of an instruction fetch |
| pc_in | input | 32 | Current program counter |
| irq_req | input | 1 | Interrupt request |
| irq_code | input | 8 | Source code used to form the vector |
| irq_info | input | 16 | Source descriptor stored on entry |
| op_valid | input | 1 | Decoded opcode strobe |
| op_code | input | 5 | Decoded opcode |
| rd_info_val | input | 16 | Register value used to restore the descriptor |
| rd_pc_val | input | 32 | Register value used to restore the program counter |
| irq_ack | output | 1 | One-clock acknowledge |
| pc_load | output | 1 | Load `pc_out` into the program counter |
| pc_out | output | 32 | New program counter value |
| ie | output | 1 | Interrupt enable flag |
| wr_en | output | 1 | Register write strobe for Save |
| wr_info_val | output | 32 | Saved descriptor, zero-extended |
| wr_pc_val | output | 32 | Saved program counter |

## Verification
The held program counter and descriptor have no port of their own. A wrong value in either stays hidden until the next Save or Return. At that point it appears one clock later on the write ports or on `pc_out`. A wrong enable flag appears at once on `ie`. It also shows up at the next fetch start with a pending request, where `irq_ack` is either missing or raised when it should not be. The bench therefore interleaves entries, Returns, Saves and Restores, so that every held value is read out soon after it is written.

// File: rtl/irq_pkg.sv
package irq_pkg;
    parameter int PC_W    = 32;
    parameter int CODE_W  = 8;
    parameter int INFO_W  = 16;
    parameter int OP_W    = 5;
    parameter int VEC_LSB = 4;
    localparam int VEC_HI_ZEROS = PC_W - CODE_W - VEC_LSB;

    typedef enum logic [OP_W-1:0] {
        OP_IEN  = 5'd10,
        OP_IDIS = 5'd11,
        OP_SAVE = 5'd16,
        OP_REST = 5'd17,
        OP_RET  = 5'd29
    } irq_op_e;

    typedef struct packed {
        logic take;
        logic ret;
        logic ien;
        logic idis;
        logic save;
        logic rest;
    } irq_act_t;

    function automatic logic [PC_W-1:0] make_vector(input logic [CODE_W-1:0] code);
        return {{VEC_HI_ZEROS{1'b0}}, code, {VEC_LSB{1'b0}}};
    endfunction
endpackage

// File: rtl/irq_decode.sv
module irq_decode
    import irq_pkg::*;
(
    input  logic            fetch_start,
    input  logic            irq_req,
    input  logic            ie,
    input  logic            op_valid,
    input  logic [OP_W-1:0] op_code,
    output irq_act_t        act
);
    logic op_ok;

    always_comb begin
        act      = '0;
        act.take = fetch_start && irq_req && ie;
        op_ok    = op_valid && !act.take;
        act.ret  = op_ok && (op_code == OP_RET);
        act.ien  = op_ok && (op_code == OP_IEN);
        act.idis = op_ok && (op_code == OP_IDIS);
        act.save = op_ok && (op_code == OP_SAVE);
        act.rest = op_ok && (op_code == OP_REST);
    end

    always_comb begin
        assert_one_action_R11: assert ($onehot0(act));
    end
endmodule

// File: rtl/irq_state.sv
module irq_state
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  irq_act_t          act,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [INFO_W-1:0] irq_info,
    input  logic [INFO_W-1:0] rd_info_val,
    input  logic [PC_W-1:0]   rd_pc_val,
    output logic              ie,
    output logic [PC_W-1:0]   saved_pc,
    output logic [INFO_W-1:0] saved_info
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ie         <= 1'b0;
            saved_pc   <= '0;
            saved_info <= '0;
        end else if (act.take) begin
            ie         <= 1'b0;
            saved_pc   <= pc_in;
            saved_info <= irq_info;
        end else begin
            if (act.ret || act.ien) ie <= 1'b1;
            else if (act.idis)      ie <= 1'b0;
            if (act.rest) begin
                saved_pc   <= rd_pc_val;
                saved_info <= rd_info_val;
            end
        end
    end

    assert_take_holds_pc_R5: assert property (@(posedge clk) disable iff (rst)
        act.take |=> (saved_pc == $past(pc_in)) && (saved_info == $past(irq_info)) && !ie);
    assert_restore_loads_R10: assert property (@(posedge clk) disable iff (rst)
        act.rest |=> (saved_pc == $past(rd_pc_val)) && (saved_info == $past(rd_info_val)));
endmodule

// File: rtl/irq_outreg.sv
module irq_outreg
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  irq_act_t          act,
    input  logic [CODE_W-1:0] irq_code,
    input  logic [PC_W-1:0]   saved_pc,
    input  logic [INFO_W-1:0] saved_info,
    output logic              irq_ack,
    output logic              pc_load,
    output logic [PC_W-1:0]   pc_out,
    output logic              wr_en,
    output logic [PC_W-1:0]   wr_info_val,
    output logic [PC_W-1:0]   wr_pc_val
);
    localparam int INFO_PAD = PC_W - INFO_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_ack     <= 1'b0;
            pc_load     <= 1'b0;
            pc_out      <= '0;
            wr_en       <= 1'b0;
            wr_info_val <= '0;
            wr_pc_val   <= '0;
        end else begin
            irq_ack     <= act.take;
            pc_load     <= act.take || act.ret;
            pc_out      <= act.take ? make_vector(irq_code) :
                           act.ret  ? saved_pc : '0;
            wr_en       <= act.save;
            wr_info_val <= act.save ? {{INFO_PAD{1'b0}}, saved_info} : '0;
            wr_pc_val   <= act.save ? saved_pc : '0;
        end
    end

    assert_save_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> wr_info_val[PC_W-1:INFO_W] == '0);
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_start,
    input  logic [PC_W-1:0]   pc_in,
    input  logic              irq_req,
    input  logic [CODE_W-1:0] irq_code,
    input  logic [INFO_W-1:0] irq_info,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic [INFO_W-1:0] rd_info_val,
    input  logic [PC_W-1:0]   rd_pc_val,
    output logic              irq_ack,
    output logic              pc_load,
    output logic [PC_W-1:0]   pc_out,
    output logic              ie,
    output logic              wr_en,
    output logic [PC_W-1:0]   wr_info_val,
    output logic [PC_W-1:0]   wr_pc_val
);
    irq_act_t          act;
    logic [PC_W-1:0]   saved_pc;
    logic [INFO_W-1:0] saved_info;

    irq_decode u_dec (
        .fetch_start(fetch_start), .irq_req(irq_req), .ie(ie),
        .op_valid(op_valid), .op_code(op_code), .act(act)
    );

    irq_state u_st (
        .clk(clk), .rst(rst), .act(act), .pc_in(pc_in), .irq_info(irq_info),
        .rd_info_val(rd_info_val), .rd_pc_val(rd_pc_val),
        .ie(ie), .saved_pc(saved_pc), .saved_info(saved_info)
    );

    irq_outreg u_out (
        .clk(clk), .rst(rst), .act(act), .irq_code(irq_code),
        .saved_pc(saved_pc), .saved_info(saved_info),
        .irq_ack(irq_ack), .pc_load(pc_load), .pc_out(pc_out),
        .wr_en(wr_en), .wr_info_val(wr_info_val), .wr_pc_val(wr_pc_val)
    );

    assert_take_acks_R2: assert property (@(posedge clk) disable iff (rst)
        (fetch_start && irq_req && ie) |=> (irq_ack && pc_load));
    assert_ack_single_R3: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> !irq_ack);
    assert_vector_shape_R4: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> (pc_out[PC_W-1:CODE_W+VEC_LSB] == '0) && (pc_out[VEC_LSB-1:0] == '0));
    assert_entry_masks_R5: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> !ie);
    assert_masked_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (fetch_start && irq_req && !ie) |=> !irq_ack);
    assert_return_enables_R7: assert property (@(posedge clk) disable iff (rst)
        (pc_load && !irq_ack) |-> ie);
endmodule

// File: tb/tb_irq_entry_ctrl.sv
module tb_irq_entry_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_start = 1'b0, irq_req = 1'b0, op_valid = 1'b0;
    logic [31:0] pc_in = '0, rd_pc_val = '0;
    logic [7:0]  irq_code = '0;
    logic [15:0] irq_info = '0, rd_info_val = '0;
    logic [4:0]  op_code = '0;
    logic        irq_ack, pc_load, ie, wr_en;
    logic [31:0] pc_out, wr_info_val, wr_pc_val;

    int checks = 0, failures = 0;
    bit done = 0;

    logic        m_ie = 0;
    logic [31:0] m_spc = '0;
    logic [15:0] m_info = '0;

    irq_entry_ctrl dut (
        .clk(clk), .rst(rst), .fetch_start(fetch_start), .pc_in(pc_in),
        .irq_req(irq_req), .irq_code(irq_code), .irq_info(irq_info),
        .op_valid(op_valid), .op_code(op_code), .rd_info_val(rd_info_val),
        .rd_pc_val(rd_pc_val), .irq_ack(irq_ack), .pc_load(pc_load),
        .pc_out(pc_out), .ie(ie), .wr_en(wr_en), .wr_info_val(wr_info_val),
        .wr_pc_val(wr_pc_val)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] vec_of(input logic [7:0] c);
        return {20'b0, c, 4'b0};
    endfunction

    task automatic cycle(input logic fs, input logic rq, input logic [7:0] cd,
                         input logic [15:0] inf, input logic [31:0] pci,
                         input logic ov, input logic [4:0] oc,
                         input logic [15:0] ri, input logic [31:0] rp, input string tag);
        logic take, opv, e_load, e_wr;
        logic [31:0] e_pc;
        fetch_start = fs; irq_req = rq; irq_code = cd; irq_info = inf; pc_in = pci;
        op_valid = ov; op_code = oc; rd_info_val = ri; rd_pc_val = rp;
        take   = fs && rq && m_ie;
        opv    = ov && !take;
        e_load = take || (opv && oc == 5'd29);
        e_pc   = take ? vec_of(cd) : (opv && oc == 5'd29) ? m_spc : 32'h0;
        e_wr   = opv && oc == 5'd16;
        chk_pending(take, e_load, e_pc, e_wr, tag);
        if (take) begin
            m_spc = pci; m_info = inf; m_ie = 0;
        end else if (opv) begin
            case (oc)
                5'd29, 5'd10: m_ie = 1;
                5'd11:        m_ie = 0;
                5'd17: begin m_info = ri; m_spc = rp; end
                default: ;
            endcase
        end
        @(posedge clk); #1;
        chk(tag, "irq_ack", {31'b0, irq_ack}, {31'b0, p_ack});
        chk(tag, "pc_load", {31'b0, pc_load}, {31'b0, p_load});
        chk(tag, "pc_out", pc_out, p_pc);
        chk(tag, "wr_en", {31'b0, wr_en}, {31'b0, p_wr});
        chk(tag, "wr_info_val", wr_info_val, p_wri);
        chk(tag, "wr_pc_val", wr_pc_val, p_wrp);
        chk(tag, "ie", {31'b0, ie}, {31'b0, m_ie});
    endtask

    logic p_ack, p_load, p_wr;
    logic [31:0] p_pc, p_wri, p_wrp;
    task automatic chk_pending(input logic t, input logic l, input logic [31:0] p, input logic w, input string tag);
        p_ack = t; p_load = l; p_pc = p; p_wr = w;
        p_wri = w ? {16'b0, m_info} : 32'h0;
        p_wrp = w ? m_spc : 32'h0;
    endtask

    task automatic idle(input string tag);
        cycle(0, 0, 8'h00, 16'h0, 32'h0, 0, 5'd0, 16'h0, 32'h0, tag);
    endtask

    task automatic op(input logic [4:0] oc, input string tag);
        cycle(0, 0, 8'h00, 16'h0, 32'h0, 1, oc, 16'h0, 32'h0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state seen at the ports
        chk("R1", "irq_ack", {31'b0, irq_ack}, 32'h0);
        chk("R1", "pc_load", {31'b0, pc_load}, 32'h0);
        chk("R1", "ie", {31'b0, ie}, 32'h0);
        rst = 0;
        op(5'd16, "R1_save_after_reset");
        idle("R9_save_drop");
        // R6: held request masked while ie is 0
        cycle(1, 1, 8'h3C, 16'h1111, 32'h100, 0, 5'd0, 16'h0, 32'h0, "R6_masked");
        cycle(1, 1, 8'h3C, 16'h1111, 32'h104, 0, 5'd0, 16'h0, 32'h0, "R6_masked");
        op(5'd10, "R8_enable");
        // R2/R4/R5: taken with code A5
        cycle(1, 1, 8'hA5, 16'hBEEF, 32'h0000_2468, 0, 5'd0, 16'h0, 32'h0, "R4_vector");
        cycle(1, 1, 8'hA5, 16'hBEEF, 32'h0000_2470, 0, 5'd0, 16'h0, 32'h0, "R3_one_pulse");
        op(5'd16, "R5_saved_values");
        op(5'd29, "R7_return");
        // R11: entry beats Save presented at same edge
        cycle(1, 1, 8'hFF, 16'hCAFE, 32'hFFFF_FFFC, 1, 5'd16, 16'h0, 32'h0, "R11_entry_wins");
        op(5'd3, "R11_unknown_op");
        op(5'd17, "R10_restore_zero");
        cycle(0, 0, 8'h00, 16'h0, 32'h0, 1, 5'd17, 16'h7777, 32'h8000_0001, "R10_restore");
        op(5'd16, "R10_readback");
        op(5'd10, "R8_enable");
        op(5'd11, "R8_disable");
        op(5'd29, "R7_return_from_disabled");
        cycle(1, 1, 8'h00, 16'h0, 32'h44, 0, 5'd0, 16'h0, 32'h0, "R4_code_zero");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] oc;
            logic [2:0] pick;
            pick = 3'($urandom_range(0, 6));
            case (pick)
                0: oc = 5'd10; 1: oc = 5'd11; 2: oc = 5'd16;
                3: oc = 5'd17; 4: oc = 5'd29;
                default: oc = 5'($urandom);
            endcase
            cycle(($urandom % 3) == 0, $urandom_range(0, 1) == 1, 8'($urandom), 16'($urandom),
                  $urandom, $urandom_range(0, 1) == 1, oc, 16'($urandom), $urandom,
                  "R2_R11_random");
        end
        finish_run();
    end
endmodule